// File: doc/BRIEF.md
# Column Ramp Converter Counter with Digital Double Sampling

This block is the digital back end of one column of a single-slope analog-to-digital converter. A ramp generator outside the block is shared by every column, and each column has its own comparator. The block sees only that comparator's output, which is asynchronous to the block's clock. It times each ramp, counts clock cycles until the comparator trips, and turns that time into a code. The counter clock is much faster than the comparator, so the clock rate sets the resolution.

Each pixel is converted twice in one conversion: once against its reset level and once against its signal level. A single signed accumulator counts down during the reset ramp and up during the signal ramp. At the end of the pair it therefore holds the signal-minus-reset difference, with no second register and no separate subtractor. The same sequencer can repeat the reset/signal pair 2^L times for correlated multiple sampling. L is chosen by a configuration input, and the summed difference is divided by 2^L with an arithmetic shift.

The block tells the ramp generator when to run each ramp and which level is being converted. Each ramp lasts a fixed number of cycles. If the comparator never trips within a ramp, that ramp's count saturates and an overflow flag is raised with the result.

Top module: `col_ramp_cds`

## Requirements
- R1: While reset is high and after it is released, `done`, `overflow`, `ramp_run` and `result` are all 0.
- R2: A start pulse in idle begins the conversion. Each of the 2^L pairs runs a reset ramp (`ramp_sig`=0) and then a signal ramp (`ramp_sig`=1). `ramp_run` stays high for exactly RST_MAX cycles on a reset ramp and exactly SIG_MAX cycles on a signal ramp. Every ramp, including the first, is preceded by exactly GAP_CYC cycles with `ramp_run` low.
- R3: Let cycle 0 be the first cycle in which `ramp_run` is high, and let k be the first cycle in which `cmp_in` is high. The phase count is then min(k+2, limit), where the +2 is the synchroniser latency. Counting stops at the first rising edge of the synchronised comparator, and later comparator activity in the same ramp has no effect.
- R4: `result` is the two's-complement value of the sum over all pairs of (signal count − reset count), arithmetically shifted right by L.
- R5: A ramp with no comparator rise before its limit contributes exactly its limit (RST_MAX or SIG_MAX) and sets `overflow` for that result. A conversion with no saturated ramp reports `overflow`=0.
- R6: `done` is high for exactly one cycle per conversion. `result` and `overflow` are valid in that cycle and hold their values until the next `done`.
- R7: A start pulse while a conversion is in progress is ignored. The ramp sequence and the result are unaffected.
- R8: `cfg_log2n` is sampled only on an accepted start, so later changes have no effect on a conversion in progress. Values above MAX_LOG2N are treated as MAX_LOG2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start-of-conversion pulse |
| cmp_in | input | 1 | Asynchronous column comparator output, high once the ramp crosses the pixel level |
| cfg_log2n | input | CFG_W | log2 of the number of reset/signal pairs |
| ramp_run | output | 1 | High while the ramp generator must sweep |
| ramp_sig | output | 1 | 0 for a reset-level ramp, 1 for a signal-level ramp |
| result | output | RES_W | Signed averaged difference code |
| overflow | output | 1 | A ramp saturated in the reported conversion |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
On every cycle, the assertions check the following: the phase counter stays within its limit, the accumulator freezes once the comparator edge has stopped a ramp, the overflow flag is sticky within a conversion, the ramp timer and pair index stay bounded, the latched sample count does not move mid-conversion, `done` lasts one cycle and `result` changes only with `done`. Other properties need the bench's scenarios, because they depend on how the comparator timing relates to the arithmetic. These are the exact count per ramp including the synchroniser offset, the saturation boundary at k+2 equal to the limit, the averaging and floor rounding of negative sums, and the clamping of the sample count.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_RAMP = 2'd2,
    ST_FIN  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/cds_seq.sv
module cds_seq
  import cds_pkg::*;
#(
  parameter int RST_MAX   = 64,
  parameter int SIG_MAX   = 256,
  parameter int GAP_CYC   = 4,
  parameter int MAX_LOG2N = 3,
  parameter int CFG_W     = 3,
  parameter int TW        = 9,
  parameter int LW        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_log2n,
  output logic             ramp_run,
  output logic             ramp_sig,
  output logic             clear,
  output logic             finish,
  output logic [LW-1:0]    log2n,
  output logic [TW-1:0]    limit
);
  localparam int PAIR_W = MAX_LOG2N + 1;
  localparam int GW     = $clog2(GAP_CYC + 1);

  seq_st_t           st;
  logic [GW-1:0]     gcnt;
  logic [TW-1:0]     tcnt;
  logic [PAIR_W-1:0] pair;
  logic [PAIR_W-1:0] last_pair;
  logic              sig;
  logic [LW-1:0]     l2q;
  logic [LW-1:0]     l2_clamped;

  always_comb begin
    if (cfg_log2n > CFG_W'(MAX_LOG2N)) l2_clamped = LW'(MAX_LOG2N);
    else                               l2_clamped = LW'(cfg_log2n);
  end

  assign last_pair = PAIR_W'((1 << l2q) - 1);
  assign limit     = sig ? TW'(SIG_MAX) : TW'(RST_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      gcnt <= '0;
      tcnt <= '0;
      pair <= '0;
      sig  <= 1'b0;
      l2q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_GAP;
          gcnt <= '0;
          pair <= '0;
          sig  <= 1'b0;
          l2q  <= l2_clamped;
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            st   <= ST_RAMP;
            tcnt <= '0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_RAMP: begin
          if (tcnt == limit - 1'b1) begin
            gcnt <= '0;
            if (sig) begin
              if (pair == last_pair) begin
                st <= ST_FIN;
              end else begin
                pair <= pair + 1'b1;
                sig  <= 1'b0;
                st   <= ST_GAP;
              end
            end else begin
              sig <= 1'b1;
              st  <= ST_GAP;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ramp_run = (st == ST_RAMP);
  assign ramp_sig = sig;
  assign clear    = (st == ST_IDLE) && start;
  assign finish   = (st == ST_FIN);
  assign log2n    = l2q;

  // R2
  ramp_timer_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RAMP) |-> (tcnt < limit));
  // R2
  pair_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (pair <= last_pair));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(l2q));
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RAMP && start) |=> (st != ST_IDLE));
endmodule

// File: rtl/cds_counter.sv
module cds_counter #(
  parameter int ACC_W = 14,
  parameter int TW    = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    run,
  input  logic                    is_sig,
  input  logic                    rise,
  input  logic [TW-1:0]           limit,
  output logic signed [ACC_W-1:0] acc,
  output logic                    ovf
);
  logic [TW-1:0] pcnt;
  logic          stopped;
  logic          count_en;

  assign count_en = run && !stopped && !rise && (pcnt < limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc     <= '0;
      ovf     <= 1'b0;
      pcnt    <= '0;
      stopped <= 1'b0;
    end else if (!run) begin
      pcnt    <= '0;
      stopped <= 1'b0;
    end else begin
      if (rise) stopped <= 1'b1;
      if (count_en) begin
        pcnt <= pcnt + 1'b1;
        acc  <= is_sig ? acc + 1'b1 : acc - 1'b1;
        if (pcnt == limit - 1'b1) ovf <= 1'b1;
      end
    end
  end

  // R5
  pcnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (pcnt <= limit));
  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && stopped && !clear) |=> $stable(acc));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clear) |=> ovf);
endmodule

// File: rtl/col_ramp_cds.sv
module col_ramp_cds #(
  parameter int RST_MAX   = 64,
  parameter int SIG_MAX   = 256,
  parameter int GAP_CYC   = 4,
  parameter int MAX_LOG2N = 3,
  parameter int CFG_W     = 3,
  parameter int SYNC_STG  = 2,
  parameter int RES_W     = $clog2(SIG_MAX + 1) + MAX_LOG2N + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    cmp_in,
  input  logic [CFG_W-1:0]        cfg_log2n,
  output logic                    ramp_run,
  output logic                    ramp_sig,
  output logic signed [RES_W-1:0] result,
  output logic                    overflow,
  output logic                    done
);
  localparam int TMAX = (SIG_MAX > RST_MAX) ? SIG_MAX : RST_MAX;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(MAX_LOG2N + 1) > 0 ? $clog2(MAX_LOG2N + 1) : 1;

  logic                    rise;
  logic                    clear;
  logic                    finish;
  logic [LW-1:0]           log2n;
  logic [TW-1:0]           limit;
  logic signed [RES_W-1:0] acc;
  logic                    acc_ovf;

  cmp_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(cmp_in), .rise(rise)
  );

  cds_seq #(
    .RST_MAX(RST_MAX), .SIG_MAX(SIG_MAX), .GAP_CYC(GAP_CYC),
    .MAX_LOG2N(MAX_LOG2N), .CFG_W(CFG_W), .TW(TW), .LW(LW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_log2n(cfg_log2n),
    .ramp_run(ramp_run), .ramp_sig(ramp_sig), .clear(clear),
    .finish(finish), .log2n(log2n), .limit(limit)
  );

  cds_counter #(.ACC_W(RES_W), .TW(TW)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .run(ramp_run),
    .is_sig(ramp_sig), .rise(rise), .limit(limit),
    .acc(acc), .ovf(acc_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        result   <= acc >>> log2n;
        overflow <= acc_ovf;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(overflow)));
  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !ramp_run);
endmodule

// File: tb/col_ramp_cds_tb.sv
module col_ramp_cds_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_MAX    = 64;
  localparam int SIG_MAX    = 256;
  localparam int GAP_CYC    = 4;
  localparam int MAX_LOG2N  = 3;
  localparam int CFG_W      = 3;
  localparam int RES_W      = $clog2(SIG_MAX + 1) + MAX_LOG2N + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_in = 1'b0;
  logic [CFG_W-1:0] cfg_log2n = '0;
  logic ramp_run, ramp_sig, overflow, done;
  logic signed [RES_W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  int kr [8];
  int ks [8];
  int ridx, sidx, phases, seq_err, t, gl, cur_k;
  bit exp_sig, cur_sig;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_ramp_cds #(
    .RST_MAX(RST_MAX), .SIG_MAX(SIG_MAX), .GAP_CYC(GAP_CYC),
    .MAX_LOG2N(MAX_LOG2N), .CFG_W(CFG_W)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in),
    .cfg_log2n(cfg_log2n), .ramp_run(ramp_run), .ramp_sig(ramp_sig),
    .result(result), .overflow(overflow), .done(done)
  );

  // Comparator model: rises at cycle k of each ramp, drops between ramps
  always @(negedge clk) begin
    if (rst) begin
      cmp_in = 1'b0;
      t = 0;
      gl = 0;
    end else if (ramp_run) begin
      if (t == 0) begin
        cur_sig = ramp_sig;
        cur_k = ramp_sig ? ks[sidx % 8] : kr[ridx % 8];
        if (ramp_sig != exp_sig) seq_err++;
        if (phases > 0 && gl != GAP_CYC) seq_err++;
        gl = 0;
      end
      if (t >= cur_k) cmp_in = 1'b1;
      t++;
    end else begin
      if (t != 0) begin
        if (t != (cur_sig ? SIG_MAX : RST_MAX)) seq_err++;
        if (cur_sig) sidx++; else ridx++;
        exp_sig = !exp_sig;
        phases++;
      end
      t = 0;
      gl++;
      cmp_in = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pc(input int k, input int lim);
    return (k + 2 >= lim) ? lim : k + 2;
  endfunction

  function automatic int exp_res(input int l2);
    int s = 0;
    for (int i = 0; i < (1 << l2); i++) s += pc(ks[i], SIG_MAX) - pc(kr[i], RST_MAX);
    return s >>> l2;
  endfunction

  function automatic int exp_ovf(input int l2);
    int o = 0;
    for (int i = 0; i < (1 << l2); i++)
      if (kr[i] + 2 >= RST_MAX || ks[i] + 2 >= SIG_MAX) o = 1;
    return o;
  endfunction

  task automatic run_conv(input int cfgv, input bit poke, input string req);
    int l2;
    int wd;
    int er, eo;
    logic signed [RES_W-1:0] held;
    l2 = (cfgv > MAX_LOG2N) ? MAX_LOG2N : cfgv;
    er = exp_res(l2);
    eo = exp_ovf(l2);
    @(negedge clk);
    ridx = 0; sidx = 0; phases = 0; seq_err = 0; exp_sig = 1'b0; gl = 0;
    cfg_log2n = CFG_W'(cfgv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (GAP_CYC + 20) @(negedge clk);
      cfg_log2n = CFG_W'((cfgv + 1) % 4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    check(wd < 20000, "R6 done timeout", wd, 0);
    check(int'(result) == er, {req, " result"}, int'(result), er);
    check(int'(overflow) == eo, {req, " overflow R5"}, int'(overflow), eo);
    check(phases == 2 * (1 << l2) && seq_err == 0, "R2 ramp sequence",
          phases * 100 + seq_err, 2 * (1 << l2) * 100);
    held = result;
    @(negedge clk);
    check(!done && result == held, "R6 pulse/hold", int'(done), 0);
  endtask

  task automatic set_all(input int r, input int s);
    for (int i = 0; i < 8; i++) begin kr[i] = r; ks[i] = s; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    set_all(10, 10);
    repeat (4) @(negedge clk);
    check(!done && !overflow && !ramp_run && result == 0, "R1 during reset", int'(result), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !overflow && !ramp_run && result == 0, "R1 after reset",
          int'({done, overflow, ramp_run}), 0);

    // R3 R4: single pair, positive difference 42-7
    set_all(5, 40);
    run_conv(0, 0, "R3 R4 positive");
    // R4: negative difference 5-52
    set_all(50, 3);
    run_conv(0, 0, "R4 negative");
    // R3: boundary just below reset limit, no overflow
    set_all(RST_MAX - 3, 100);
    run_conv(0, 0, "R3 reset limit-1");
    // R5: reset saturates exactly at limit
    set_all(RST_MAX - 2, 100);
    run_conv(0, 0, "R5 reset saturate");
    // R5: signal comparator never rises
    set_all(4, SIG_MAX + 50);
    run_conv(1, 0, "R5 signal saturate");
    // R4: averaging of 4 pairs with negative floor
    kr[0] = 20; ks[0] = 3; kr[1] = 7; ks[1] = 8;
    kr[2] = 30; ks[2] = 1; kr[3] = 2; ks[3] = 2;
    run_conv(2, 0, "R4 average floor");
    // R8: cfg above max clamps to 8 pairs
    for (int i = 0; i < 8; i++) begin kr[i] = i * 3; ks[i] = 20 + i * 11; end
    run_conv(6, 0, "R8 clamp");
    // R7 R8: start and cfg change during conversion ignored
    run_conv(2, 1, "R7 R8 busy start");

    // Random stimulus
    for (int n = 0; n < 20; n++) begin
      int c;
      for (int i = 0; i < 8; i++) begin
        kr[i] = $urandom_range(RST_MAX + 2, 0);
        ks[i] = $urandom_range(SIG_MAX + 2, 0);
      end
      c = $urandom_range(4, 0);
      run_conv(c, 0, "R3 R4 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule